// File: doc/BRIEF.md
# Two-wire addressed serial slave with wiper stepping

This block is the bus-facing front end of a dual digital potentiometer controller. It watches an open-drain two-wire bus (a clock line and a data line) from a fast system clock. Both lines pass through a short synchroniser, and start and stop conditions are recognised on the synchronised copies. After a start condition the block shifts in an address byte. It answers only when the byte carries the fixed type nibble and the value on four strap pins, and only when no internal nonvolatile write is busy. It then takes an instruction byte and hands it to a command engine. Depending on the opcode, it next takes a data byte from the master, shifts a read value out to the master, or enters a stepping mode.

The block never drives the data line high. It only asserts `sda_oe`, which pulls the line low. Acknowledges and read bits are applied after a clock falling edge, so the data line never moves while the clock is high. In stepping mode the block stops framing bytes. It reports every clock high pulse as one step, with the direction taken from the data line level, until a stop condition arrives.

Top module: `tw_slave`

## Requirements
- R1: A start condition (data falling while clock high) aborts any transfer in progress, releases the data line and restarts address reception with a fresh bit count. A partly received byte is never delivered.
- R2: A stop condition (data rising while clock high) releases the data line and returns the block to idle, ending stepping mode. In idle, clock pulses and bytes produce no acknowledge and no output pulse until the next start.
- R3: The address byte is acknowledged only when it equals {4'b0101, strap[3:0]} (type nibble in bits 7:4). On any mismatch the block leaves the line released and ignores the bus until the next start.
- R4: While `nv_busy` is high at the eighth address bit, the address is not acknowledged. A later start with a matching address while `nv_busy` is low is acknowledged.
- R5: The instruction byte is always acknowledged. It appears on `cmd_byte` with a single-cycle `cmd_valid` pulse, and at most one of `cmd_valid`, `data_valid` and `step_valid` is high in any cycle.
- R6: After an instruction whose opcode (bits 7:4) is neither 4'b1001, 4'b1011 nor 4'b0010, the next byte is acknowledged and delivered on `data_byte` with a single-cycle `data_valid` pulse. Bytes after it are ignored.
- R7: After an instruction with opcode 4'b1001 or 4'b1011, the block shifts out {2'b00, rd_value} MSB first, one bit per clock. It then releases the line for the master's acknowledge and ignores the bus until the next start or stop.
- R8: After an instruction with opcode 4'b0010, each clock high pulse gives one `step_valid` pulse while the clock is high. `step_up` is 1 when the data line is high (step toward the high terminal) and 0 when it is low.
- R9: `sda_oe` changes only while the clock is low. An acknowledge is asserted after the falling edge that ends the eighth bit and removed after the falling edge that ends the ninth clock.
- R10: During and right after reset, `sda_oe`, `cmd_valid`, `data_valid` and `step_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| strap | input | 4 | Address strap pins, low nibble of the address |
| nv_busy | input | 1 | High while an internal nonvolatile write is running |
| rd_value | input | 6 | Value returned on read instructions |
| sda_oe | output | 1 | Pull the data line low when high |
| cmd_valid | output | 1 | One-cycle pulse: instruction byte received |
| cmd_byte | output | 8 | Last received instruction byte |
| data_valid | output | 1 | One-cycle pulse: data byte received |
| data_byte | output | 8 | Last received data byte |
| step_valid | output | 1 | One-cycle pulse per clock high pulse in stepping mode |
| step_up | output | 1 | Direction of the reported step, 1 means up |

## Verification
A write transfer with a trailing extra byte separates data delivery from the idle state that should follow it. Addresses with a wrong type nibble, a wrong strap bit, or a correct value while a write is busy show which field, or the busy input, blocks the acknowledge. Two read opcodes with different values, one of them all ones, check the bit order and the zero padding. An uneven up/down stepping pattern, followed by a stop, clock pulses and a byte sent without a start, shows that stepping counts both directions and ends cleanly. A repeated start inside an instruction byte shows that no partial byte leaks out.

// File: rtl/tw_slave_pkg.sv
package tw_slave_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_INSTR,
        PH_WDATA,
        PH_RDATA,
        PH_STEP
    } phase_t;

    typedef enum logic [1:0] {
        OPC_WRITE,
        OPC_READ,
        OPC_STEP
    } opclass_t;

    localparam logic [3:0] OP_RD_WIPER = 4'b1001;
    localparam logic [3:0] OP_RD_REG   = 4'b1011;
    localparam logic [3:0] OP_STEP     = 4'b0010;

endpackage

// File: rtl/tw_slave_sync.sv
module tw_slave_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic q_prev
);
    // STAGES flops of synchroniser plus one delayed copy for edge detection
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-1:0], d};
    end

    assign q      = chain_q[STAGES-1];
    assign q_prev = chain_q[STAGES];
endmodule

// File: rtl/tw_slave_opclass.sv
module tw_slave_opclass
    import tw_slave_pkg::*;
(
    input  logic [3:0] op,
    output opclass_t   cls
);
    always_comb begin
        if (op == OP_RD_WIPER || op == OP_RD_REG) cls = OPC_READ;
        else if (op == OP_STEP)                     cls = OPC_STEP;
        else                                        cls = OPC_WRITE;
    end
endmodule

// File: rtl/tw_slave.sv
module tw_slave
    import tw_slave_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_W      = 8,
    parameter int STRAP_W     = 4,
    parameter int VAL_W       = 6,
    parameter logic [BYTE_W-STRAP_W-1:0] TYPE_ID = 4'b0101
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic [STRAP_W-1:0] strap,
    input  logic               nv_busy,
    input  logic [VAL_W-1:0]   rd_value,
    output logic               sda_oe,
    output logic               cmd_valid,
    output logic [BYTE_W-1:0]  cmd_byte,
    output logic               data_valid,
    output logic [BYTE_W-1:0]  data_byte,
    output logic               step_valid,
    output logic               step_up
);
    localparam int CNT_W = $clog2(BYTE_W + 2);
    localparam int IDX_W = $clog2(BYTE_W);
    localparam int PAD_W = BYTE_W - VAL_W;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] TAIL     = CNT_W'(BYTE_W + 1);

    typedef struct packed {
        phase_t              ph;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   sh;
        logic                oe;
        logic                cmd_v;
        logic [BYTE_W-1:0]   cmd;
        logic                dat_v;
        logic [BYTE_W-1:0]   dat;
        logic                stp_v;
        logic                stp_up;
    } state_t;

    state_t st_d, st_q;

    // line synchronisers: index 0 = clock line, index 1 = data line
    logic [1:0] raw_w, lvl_w, prv_w;
    assign raw_w = {sda_in, scl_in};

    for (genvar g = 0; g < 2; g++) begin : g_line
        tw_slave_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .d      (raw_w[g]),
            .q      (lvl_w[g]),
            .q_prev (prv_w[g])
        );
    end

    logic scl_rise, scl_fall, bus_start, bus_stop, sda_s;
    assign sda_s     = lvl_w[1];
    assign scl_rise  = lvl_w[0] & ~prv_w[0];
    assign scl_fall  = ~lvl_w[0] & prv_w[0];
    assign bus_start = lvl_w[0] & prv_w[0] & prv_w[1] & ~lvl_w[1];
    assign bus_stop  = lvl_w[0] & prv_w[0] & ~prv_w[1] & lvl_w[1];

    opclass_t op_cls;
    tw_slave_opclass u_opclass (
        .op  (st_q.cmd[BYTE_W-1 -: 4]),
        .cls (op_cls)
    );

    logic [BYTE_W-1:0] byte_in, rd_load;
    logic [IDX_W-1:0]  rd_idx;
    logic              addr_hit;

    assign byte_in  = {st_q.sh[BYTE_W-2:0], sda_s};
    assign rd_load  = {{PAD_W{1'b0}}, rd_value};
    assign rd_idx   = IDX_W'(LAST_BIT - st_q.cnt);
    assign addr_hit = (byte_in == {TYPE_ID, strap}) && !nv_busy;

    always_comb begin
        st_d       = st_q;
        st_d.cmd_v = 1'b0;
        st_d.dat_v = 1'b0;
        st_d.stp_v = 1'b0;
        if (bus_start) begin
            st_d.ph  = PH_ADDR;
            st_d.cnt = '0;
            st_d.oe  = 1'b0;
        end else if (bus_stop) begin
            st_d.ph  = PH_IDLE;
            st_d.cnt = '0;
            st_d.oe  = 1'b0;
        end else begin
            case (st_q.ph)
                PH_IDLE: ;
                PH_STEP: begin
                    if (scl_rise) begin
                        st_d.stp_v  = 1'b1;
                        st_d.stp_up = sda_s;
                    end
                end
                PH_RDATA: begin
                    if (scl_rise && st_q.cnt < TAIL) st_d.cnt = st_q.cnt + 1'b1;
                    if (scl_fall) begin
                        if (st_q.cnt != '0 && st_q.cnt < ACK_SLOT) begin
                            st_d.oe = ~st_q.sh[rd_idx];
                        end else if (st_q.cnt == ACK_SLOT) begin
                            st_d.oe = 1'b0;
                        end else if (st_q.cnt == TAIL) begin
                            st_d.ph  = PH_IDLE;
                            st_d.cnt = '0;
                        end
                    end
                end
                default: begin
                    if (scl_rise) begin
                        if (st_q.cnt < ACK_SLOT) begin
                            st_d.sh  = byte_in;
                            st_d.cnt = st_q.cnt + 1'b1;
                            if (st_q.cnt == LAST_BIT) begin
                                if (st_q.ph == PH_ADDR && !addr_hit) begin
                                    st_d.ph  = PH_IDLE;
                                    st_d.cnt = '0;
                                end else if (st_q.ph == PH_INSTR) begin
                                    st_d.cmd_v = 1'b1;
                                    st_d.cmd   = byte_in;
                                end else if (st_q.ph == PH_WDATA) begin
                                    st_d.dat_v = 1'b1;
                                    st_d.dat   = byte_in;
                                end
                            end
                        end else if (st_q.cnt == ACK_SLOT) begin
                            st_d.cnt = TAIL;
                        end
                    end
                    if (scl_fall) begin
                        if (st_q.cnt == ACK_SLOT) begin
                            st_d.oe = 1'b1;
                        end else if (st_q.cnt == TAIL) begin
                            st_d.oe  = 1'b0;
                            st_d.cnt = '0;
                            if (st_q.ph == PH_ADDR) begin
                                st_d.ph = PH_INSTR;
                            end else if (st_q.ph == PH_INSTR) begin
                                case (op_cls)
                                    OPC_READ: begin
                                        st_d.ph = PH_RDATA;
                                        st_d.sh = rd_load;
                                        st_d.oe = ~rd_load[BYTE_W-1];
                                    end
                                    OPC_STEP: st_d.ph = PH_STEP;
                                    default:  st_d.ph = PH_WDATA;
                                endcase
                            end else begin
                                st_d.ph = PH_IDLE;
                            end
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sda_oe     = st_q.oe;
    assign cmd_valid  = st_q.cmd_v;
    assign cmd_byte   = st_q.cmd;
    assign data_valid = st_q.dat_v;
    assign data_byte  = st_q.dat;
    assign step_valid = st_q.stp_v;
    assign step_up    = st_q.stp_up;
endmodule

// File: rtl/tw_slave_chk.sv
module tw_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic sda_oe,
    input logic cmd_valid,
    input logic data_valid,
    input logic step_valid
);
    // R9
    oe_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_in);

    // R9
    oe_fall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_in);

    // R5
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R6
    data_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid);

    // R8
    step_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |-> scl_in);

    // R5
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, data_valid, step_valid}));
endmodule

bind tw_slave tw_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl_in),
    .sda_oe     (sda_oe),
    .cmd_valid  (cmd_valid),
    .data_valid (data_valid),
    .step_valid (step_valid)
);

// File: tb/sim_tw_slave.sv
module sim_tw_slave;
    localparam int Q = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n, m_scl, m_sda, nv_busy;
    logic [3:0] strap;
    logic [5:0] rd_value;
    logic       sda_oe, cmd_valid, data_valid, step_valid, step_up;
    logic [7:0] cmd_byte, data_byte;
    logic       sda_bus;
    assign sda_bus = m_sda & ~sda_oe;

    tw_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
        .strap(strap), .nv_busy(nv_busy), .rd_value(rd_value),
        .sda_oe(sda_oe), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .data_valid(data_valid), .data_byte(data_byte),
        .step_valid(step_valid), .step_up(step_up)
    );

    int checks = 0, errors = 0;
    int cmd_cnt = 0, dat_cnt = 0, step_cnt = 0, up_cnt = 0;
    logic [7:0] last_cmd = 8'h00, last_dat = 8'h00;
    logic last_up = 1'b0;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // behavioural reference model, advanced on every rising clock edge
    logic [1:0] hist[$];
    logic [1:0] mo, mn;
    int         md, nb;
    logic [7:0] acc, rdbyte, e_cb, e_db;
    logic       e_oe, e_cv, e_dv, e_sv, e_su;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{2'b11, 2'b11, 2'b11, 2'b11};
            md = 0; nb = 0; acc = 0; rdbyte = 0; e_cb = 0; e_db = 0;
            e_oe = 0; e_cv = 0; e_dv = 0; e_sv = 0; e_su = 0;
        end else begin
            hist.push_back({m_scl, m_sda & ~e_oe});
            void'(hist.pop_front());
            mo = hist[0];
            mn = hist[1];
            e_cv = 0; e_dv = 0; e_sv = 0;
            if (mo == 2'b11 && mn == 2'b10) begin
                md = 1; nb = 0; e_oe = 0;
            end else if (mo == 2'b10 && mn == 2'b11) begin
                md = 0; nb = 0; e_oe = 0;
            end else if (md == 5) begin
                if (!mo[1] && mn[1]) begin e_sv = 1; e_su = mn[0]; end
            end else if (md != 0) begin
                if (!mo[1] && mn[1]) begin
                    if (nb < 8) begin
                        acc = {acc[6:0], mn[0]};
                        nb++;
                        if (nb == 8) begin
                            if (md == 1 && (acc != {4'b0101, strap} || nv_busy)) begin
                                md = 0; nb = 0;
                            end else if (md == 2) begin
                                e_cv = 1; e_cb = acc;
                            end else if (md == 3) begin
                                e_dv = 1; e_db = acc;
                            end
                        end
                    end else if (nb == 8) nb = 9;
                end
                if (mo[1] && !mn[1]) begin
                    if (md == 4) begin
                        if (nb >= 1 && nb <= 7) e_oe = !rdbyte[7-nb];
                        else if (nb == 8) e_oe = 0;
                        else if (nb == 9) begin md = 0; nb = 0; end
                    end else if (nb == 8) e_oe = 1;
                    else if (nb == 9) begin
                        e_oe = 0; nb = 0;
                        if (md == 1) md = 2;
                        else if (md == 2) begin
                            case (e_cb[7:4])
                                4'h9, 4'hB: begin
                                    md = 4; rdbyte = {2'b00, rd_value}; e_oe = !rdbyte[7];
                                end
                                4'h2:    md = 5;
                                default: md = 3;
                            endcase
                        end else md = 0;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check("R9 sda_oe vs model", int'(sda_oe), int'(e_oe));
            check("R5 cmd_valid vs model", int'(cmd_valid), int'(e_cv));
            if (e_cv) check("R5 cmd_byte vs model", int'(cmd_byte), int'(e_cb));
            check("R6 data_valid vs model", int'(data_valid), int'(e_dv));
            if (e_dv) check("R6 data_byte vs model", int'(data_byte), int'(e_db));
            check("R8 step_valid vs model", int'(step_valid), int'(e_sv));
            if (e_sv) check("R8 step_up vs model", int'(step_up), int'(e_su));
            if (cmd_valid) begin cmd_cnt++; last_cmd = cmd_byte; end
            if (data_valid) begin dat_cnt++; last_dat = data_byte; end
            if (step_valid) begin step_cnt++; last_up = step_up; if (step_up) up_cnt++; end
        end
    end

    task automatic waitq(int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic do_start;
        m_sda = 1'b1; waitq();
        m_scl = 1'b1; waitq();
        m_sda = 1'b0; waitq();
        m_scl = 1'b0; waitq();
    endtask

    task automatic do_stop;
        m_sda = 1'b0; waitq();
        m_scl = 1'b1; waitq();
        m_sda = 1'b1; waitq(2);
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        m_sda = b; waitq();
        m_scl = 1'b1; waitq();
        seen = sda_bus; waitq();
        m_scl = 1'b0; waitq();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, ack);
    endtask

    task automatic get_byte(output logic [7:0] v, input logic mack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            v[i] = s;
        end
        clk_bit(mack, s);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired, all requirements");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic a, s;
        logic [7:0] v;
        int c0, d0, s0, u0c;
        m_scl = 1'b1; m_sda = 1'b1; nv_busy = 1'b0; strap = 4'hA; rd_value = 6'h2D;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 sda_oe in reset", int'(sda_oe), 0);
        check("R10 pulses in reset", int'({cmd_valid, data_valid, step_valid}), 0);
        rst_n = 1'b1;
        waitq(2);
        check("R10 sda_oe after reset", int'(sda_oe), 0);

        // write transfer with trailing byte
        do_start();
        put_byte(8'h5A, a); check("R3 matching address ack", int'(a), 0);
        put_byte(8'hC6, a); check("R5 instruction ack", int'(a), 0);
        check("R5 instruction byte", int'(last_cmd), 8'hC6);
        put_byte(8'h2A, a); check("R6 data ack", int'(a), 0);
        check("R6 data byte", int'(last_dat), 8'h2A);
        d0 = dat_cnt;
        put_byte(8'h11, a); check("R6 extra byte not acked", int'(a), 1);
        check("R6 extra byte not delivered", dat_cnt, d0);
        do_stop();

        // wrong type nibble, then wrong strap bit
        c0 = cmd_cnt;
        do_start();
        put_byte(8'h4A, a); check("R3 wrong type nibble no ack", int'(a), 1);
        put_byte(8'h90, a); check("R3 ignored after mismatch", int'(a), 1);
        check("R3 no instruction after mismatch", cmd_cnt, c0);
        do_stop();
        do_start();
        put_byte(8'h5B, a); check("R3 wrong strap bit no ack", int'(a), 1);
        do_stop();

        // busy nonvolatile write
        nv_busy = 1'b1;
        do_start();
        put_byte(8'h5A, a); check("R4 busy address no ack", int'(a), 1);
        do_stop();
        nv_busy = 1'b0;
        do_start();
        put_byte(8'h5A, a); check("R4 ack after busy clears", int'(a), 0);
        do_stop();

        // reads
        do_start();
        put_byte(8'h5A, a);
        put_byte(8'h90, a); check("R7 read instruction ack", int'(a), 0);
        get_byte(v, 1'b1); check("R7 read wiper value", int'(v), 8'h2D);
        check("R7 line released after read", int'(sda_oe), 0);
        do_stop();
        rd_value = 6'h3F;
        do_start();
        put_byte(8'h5A, a);
        put_byte(8'hB4, a);
        get_byte(v, 1'b1); check("R7 read register padded", int'(v), 8'h3F);
        do_stop();

        // stepping mode
        do_start();
        put_byte(8'h5A, a);
        put_byte(8'h20, a); check("R8 step instruction ack", int'(a), 0);
        s0 = step_cnt; u0c = up_cnt;
        clk_bit(1'b1, s); clk_bit(1'b1, s); clk_bit(1'b0, s);
        clk_bit(1'b1, s); clk_bit(1'b0, s);
        check("R8 step count", step_cnt - s0, 5);
        check("R8 up step count", up_cnt - u0c, 3);
        check("R8 last step down", int'(last_up), 0);
        do_stop();
        s0 = step_cnt; c0 = cmd_cnt;
        m_scl = 1'b0; waitq();
        clk_bit(1'b1, s); clk_bit(1'b1, s);
        put_byte(8'h5A, a);
        m_scl = 1'b1; waitq();
        check("R2 no steps after stop", step_cnt - s0, 0);
        check("R2 byte without start not acked", int'(a), 1);
        check("R2 nothing delivered in idle", cmd_cnt, c0);

        // repeated start inside an instruction byte
        do_start();
        put_byte(8'h5A, a);
        c0 = cmd_cnt;
        clk_bit(1'b0, s); clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b1, s);
        do_start();
        put_byte(8'h5A, a); check("R1 address after repeated start", int'(a), 0);
        put_byte(8'h55, a); check("R1 instruction after repeated start", int'(a), 0);
        check("R1 single instruction delivered", cmd_cnt - c0, 1);
        check("R1 instruction byte", int'(last_cmd), 8'h55);
        do_stop();

        waitq(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule